// File: doc/BRIEF.md
# Pulse-Width DAC Generator with Rate-Multiplier Fine Steps

This block drives one output pin with a pulse train. After an external low-pass filter the pin works as a coarse digital-to-analog converter. Each pulse period lasts 64 clocks. A 6-bit duty value sets the base number of high clocks in every period.

Periods are grouped into a repeating frame of 16. A 4-bit rate-multiplier value picks a subset of those periods. Each selected period gets one extra high clock at the front of its pulse. Averaged over a frame, this gives sixteenth-step refinements between the base duty levels. A polarity control inverts the pin. With the duty and multiplier both at zero and the polarity set, the pin is a steady high, so it can serve as a plain output.

The three settings are written through plain write strobes into shadow copies. The working copies change only at the first clock of a frame, so a write never produces a cut or doubled pulse. There is no data stream at the edge of this block, so there is no valid/ready handshake and no back-pressure. Every port is a plain control pin.

Top module: `pwm_brm_gen`

## Requirements
- R1: The period position counts 0..63 and wraps. The frame index counts 0..15 and advances when the position wraps. With no extension, the pin (polarity 0) is high for exactly the first `duty` clocks of each period, at positions 0..duty-1.
- R2: With duty 0, multiplier 0 and polarity 0 working, the pin stays low for every clock.
- R3: A multiplier bit adds one high clock to the periods it selects. Bit 3 selects the odd periods. Bit 2 selects periods 2, 6, 10 and 14. Bit 1 selects periods 4 and 12. Bit 0 selects period 8. Several set bits select the union of their periods, and a selected period is high for positions 0..duty.
- R4: Frame period 0 is never extended, whatever the multiplier value.
- R5: With duty 0x3F and multiplier 0xF, the pin is high for all 64 clocks of periods 1..15. In period 0 it is low only at position 63.
- R6: When polarity is 1, the pin is the inverse of the polarity-0 waveform. With duty 0 and multiplier 0, it is therefore high on every clock.
- R7: Each write strobe (`duty_we`, `mult_we`, `pol_we`) stores its value in a shadow register. Shadow values are copied to the working registers at the clock edge that starts frame period 0, position 0. A write made in the last clock of a frame takes effect one frame later.
- R8: A synchronous `rst` clears the counters and all shadow and working registers. From the edge that samples reset, the pin is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one clock is one step of pulse resolution |
| rst | input | 1 | Synchronous reset, active high |
| duty_we | input | 1 | Write strobe for the duty shadow register |
| duty_wdata | input | 6 | Duty value, in high clocks per period |
| mult_we | input | 1 | Write strobe for the multiplier shadow register |
| mult_wdata | input | 4 | Multiplier period-select bits |
| pol_we | input | 1 | Write strobe for the polarity shadow bit |
| pol_wdata | input | 1 | Polarity; 1 inverts the pin |
| pwm_out | output | 1 | Pulse output pin |

## Verification
The pin is decoded without a register from the position, frame and working registers. A state change at a clock edge therefore shows on the pin within the same cycle. A write takes effect only at the first clock of the next frame, up to 1024 cycles after the strobe, or 1025 cycles for a write in the frame's last clock. The bench keeps a behavioural model that updates at each rising edge and compares the pin at each falling edge, so every due time is met without a fixed delay. The high clocks counted in each period of the last full frame give exact counts for the duty, extension and frame-boundary cases.

// File: rtl/pwm_brm_pkg.sv
package pwm_brm_pkg;
  // default geometry: 2**6 clocks per period, 2**4 periods per frame
  localparam int unsigned DEF_POS_W = 6;
  localparam int unsigned DEF_FRM_W = 4;
endpackage

// File: rtl/pwm_brm_timebase.sv
module pwm_brm_timebase #(
  parameter int unsigned POS_W = 6,
  parameter int unsigned FRM_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  output logic [POS_W-1:0] pos,
  output logic [FRM_W-1:0] frm,
  output logic             frame_last
);
  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};
  localparam logic [FRM_W-1:0] FRM_MAX = {FRM_W{1'b1}};

  logic pos_wrap;
  assign pos_wrap   = (pos == POS_MAX);
  assign frame_last = pos_wrap && (frm == FRM_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos <= '0;
      frm <= '0;
    end else begin
      pos <= pos + 1'b1;
      if (pos_wrap) frm <= frm + 1'b1;
    end
  end

  // R1
  pos_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (pos == POS_MAX) |=> (pos == '0));
  // R1
  frm_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pos != POS_MAX) |=> $stable(frm));
endmodule

// File: rtl/pwm_brm_regs.sv
module pwm_brm_regs #(
  parameter int unsigned POS_W = 6,
  parameter int unsigned FRM_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             duty_we,
  input  logic [POS_W-1:0] duty_wdata,
  input  logic             mult_we,
  input  logic [FRM_W-1:0] mult_wdata,
  input  logic             pol_we,
  input  logic             pol_wdata,
  input  logic             load,
  output logic [POS_W-1:0] duty_q,
  output logic [FRM_W-1:0] mult_q,
  output logic             pol_q
);
  logic [POS_W-1:0] duty_sh;
  logic [FRM_W-1:0] mult_sh;
  logic             pol_sh;

  // shadow side
  always_ff @(posedge clk) begin
    if (rst) begin
      duty_sh <= '0;
      mult_sh <= '0;
      pol_sh  <= 1'b0;
    end else begin
      if (duty_we) duty_sh <= duty_wdata;
      if (mult_we) mult_sh <= mult_wdata;
      if (pol_we)  pol_sh  <= pol_wdata;
    end
  end

  // working side, refreshed only at the frame boundary
  always_ff @(posedge clk) begin
    if (rst) begin
      duty_q <= '0;
      mult_q <= '0;
      pol_q  <= 1'b0;
    end else if (load) begin
      duty_q <= duty_sh;
      mult_q <= mult_sh;
      pol_q  <= pol_sh;
    end
  end

  // R7
  work_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(duty_q) && $stable(mult_q) && $stable(pol_q)));
  // R7
  work_take_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (duty_q == $past(duty_sh) && mult_q == $past(mult_sh)));
endmodule

// File: rtl/pwm_brm_decode.sv
module pwm_brm_decode #(
  parameter int unsigned FRM_W = 4
) (
  input  logic [FRM_W-1:0] frm,
  input  logic [FRM_W-1:0] mult,
  output logic             stretch
);
  // The lowest set bit of the frame index picks the multiplier bit:
  // bit i lowest -> mult[FRM_W-1-i]; index 0 selects nothing.
  logic [FRM_W-1:0] pick;

  for (genvar i = 0; i < FRM_W; i++) begin : g_pick
    if (i == 0) begin : g_lsb
      assign pick[i] = frm[0];
    end else begin : g_up
      assign pick[i] = frm[i] && (frm[i-1:0] == '0);
    end
  end

  always_comb begin
    stretch = 1'b0;
    for (int i = 0; i < FRM_W; i++) begin
      if (pick[i] && mult[FRM_W-1-i]) stretch = 1'b1;
    end
  end

  // R3
  pick_onehot_chk: assert final ($onehot0(pick));
  // R4
  no_stretch_p0_chk: assert final (!(frm == '0 && stretch));
endmodule

// File: rtl/pwm_brm_gen.sv
module pwm_brm_gen
  import pwm_brm_pkg::*;
#(
  parameter int unsigned POS_W = DEF_POS_W,
  parameter int unsigned FRM_W = DEF_FRM_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             duty_we,
  input  logic [POS_W-1:0] duty_wdata,
  input  logic             mult_we,
  input  logic [FRM_W-1:0] mult_wdata,
  input  logic             pol_we,
  input  logic             pol_wdata,
  output logic             pwm_out
);
  localparam int unsigned CMP_W = POS_W + 1;

  logic [POS_W-1:0] pos;
  logic [FRM_W-1:0] frm;
  logic             frame_last;
  logic [POS_W-1:0] duty_q;
  logic [FRM_W-1:0] mult_q;
  logic             pol_q;
  logic             stretch;
  logic [CMP_W-1:0] high_len;
  logic             active;

  pwm_brm_timebase #(.POS_W(POS_W), .FRM_W(FRM_W)) u_tb (
    .clk(clk), .rst(rst), .pos(pos), .frm(frm), .frame_last(frame_last)
  );

  pwm_brm_regs #(.POS_W(POS_W), .FRM_W(FRM_W)) u_regs (
    .clk(clk), .rst(rst),
    .duty_we(duty_we), .duty_wdata(duty_wdata),
    .mult_we(mult_we), .mult_wdata(mult_wdata),
    .pol_we(pol_we), .pol_wdata(pol_wdata),
    .load(frame_last),
    .duty_q(duty_q), .mult_q(mult_q), .pol_q(pol_q)
  );

  pwm_brm_decode #(.FRM_W(FRM_W)) u_dec (
    .frm(frm), .mult(mult_q), .stretch(stretch)
  );

  // the extra clock sits at the front: positions 0..duty instead of 0..duty-1
  assign high_len = {1'b0, duty_q} + {{POS_W{1'b0}}, stretch};
  assign active   = ({1'b0, pos} < high_len);
  assign pwm_out  = active ^ pol_q;

  // R8
  rst_low_chk: assert property (@(posedge clk) rst |=> !pwm_out);
  // R6
  pol_steady_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_last |=> $stable(pol_q));
endmodule

// File: tb/tb_pwm_brm_gen.sv
module tb_pwm_brm_gen;
  localparam int CLK_NS = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic duty_we = 1'b0, mult_we = 1'b0, pol_we = 1'b0;
  logic [5:0] duty_wdata = '0;
  logic [3:0] mult_wdata = '0;
  logic pol_wdata = 1'b0;
  logic pwm_out;

  always #(CLK_NS/2) clk = ~clk;

  pwm_brm_gen dut (
    .clk(clk), .rst(rst),
    .duty_we(duty_we), .duty_wdata(duty_wdata),
    .mult_we(mult_we), .mult_wdata(mult_wdata),
    .pol_we(pol_we), .pol_wdata(pol_wdata),
    .pwm_out(pwm_out)
  );

  int n_cmp = 0, n_bad = 0;
  string cur_tag = "R8";

  // behavioural model state
  int m_pos = 0, m_frm = 0;
  int sh_d = 0, sh_m = 0, sh_p = 0;
  int wk_d = 0, wk_m = 0, wk_p = 0;
  bit m_ok = 0;
  int hi_acc = 0;
  int last_hi [16];

  function automatic bit m_ext(int f, int m);
    if (f == 0) return 0;
    return (m[3] && (f % 2 == 1)) || (m[2] && (f % 4 == 2)) ||
           (m[1] && (f % 8 == 4)) || (m[0] && (f == 8));
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_pos = 0; m_frm = 0;
      sh_d = 0; sh_m = 0; sh_p = 0;
      wk_d = 0; wk_m = 0; wk_p = 0;
      m_ok = 1;
    end else begin
      if (m_pos == 63 && m_frm == 15) begin
        wk_d = sh_d; wk_m = sh_m; wk_p = sh_p;
      end
      if (duty_we) sh_d = duty_wdata;
      if (mult_we) sh_m = mult_wdata;
      if (pol_we)  sh_p = pol_wdata;
      m_pos = (m_pos + 1) % 64;
      if (m_pos == 0) m_frm = (m_frm + 1) % 16;
    end
  end

  always @(negedge clk) begin
    if (m_ok) begin
      bit e;
      e = ((m_pos < wk_d + m_ext(m_frm, wk_m)) ? 1'b1 : 1'b0) ^ wk_p[0];
      n_cmp++;
      if (pwm_out !== e) begin
        n_bad++;
        $display("FAIL %s: pin at frame %0d pos %0d got %b expected %b",
                 cur_tag, m_frm, m_pos, pwm_out, e);
      end
      if (rst) hi_acc = 0;
      else begin
        hi_acc += int'(pwm_out);
        if (m_pos == 63) begin
          last_hi[m_frm] = hi_acc;
          hi_acc = 0;
        end
      end
    end
  end

  task automatic chk(int got, int exp, string tag);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic set_all(int d, int m, int p);
    @(posedge clk); #1;
    duty_we = 1; duty_wdata = 6'(d);
    mult_we = 1; mult_wdata = 4'(m);
    pol_we = 1;  pol_wdata = p[0];
    @(posedge clk); #1;
    duty_we = 0; mult_we = 0; pol_we = 0;
  endtask

  task automatic wait_load_cycle();
    do @(negedge clk); while (!(m_pos == 63 && m_frm == 15));
  endtask

  // apply settings, then run one whole frame that uses them
  task automatic settle(int d, int m, int p);
    set_all(d, m, p);
    wait_load_cycle();
    repeat (1024) @(negedge clk);
    #1;
  endtask

  bit done = 0;
  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(int'(pwm_out), 0, "R8 reset level");
    @(posedge clk); #1; rst = 0;

    cur_tag = "R2";
    repeat (1100) @(negedge clk); #1;
    chk(last_hi[0], 0, "R2 idle period 0");
    chk(last_hi[7], 0, "R2 idle period 7");

    cur_tag = "R3";
    settle(8'h18, 4'h6, 0);
    chk(last_hi[1], 24, "R1 base width period 1");
    chk(last_hi[0], 24, "R4 period 0 unextended");
    chk(last_hi[2], 25, "R3 bit2 period 2");
    chk(last_hi[4], 25, "R3 bit1 period 4");
    chk(last_hi[12], 25, "R3 bit1 period 12");
    chk(last_hi[8], 24, "R3 bit0 clear period 8");

    cur_tag = "R5";
    settle(8'h3F, 4'hF, 0);
    chk(last_hi[0], 63, "R5 period 0 one low clock");
    chk(last_hi[8], 64, "R5 period 8 full");
    chk(last_hi[15], 64, "R5 period 15 full");

    cur_tag = "R6";
    settle(0, 0, 1);
    chk(last_hi[0], 64, "R6 inverted idle period 0");
    chk(last_hi[9], 64, "R6 inverted idle period 9");
    settle(8'h10, 0, 1);
    chk(last_hi[3], 48, "R6 inverted duty 16");

    cur_tag = "R7";
    settle(8'h10, 4'h9, 0);
    chk(last_hi[8], 17, "R3 bit0 period 8");
    repeat (200) @(negedge clk);
    set_all(8'h30, 4'h9, 0);
    repeat (300) @(negedge clk); #1;
    chk(last_hi[5], 17, "R7 mid-frame write deferred");
    wait_load_cycle();
    repeat (1024) @(negedge clk); #1;
    chk(last_hi[5], 49, "R7 write applied next frame");

    wait_load_cycle();
    #1; duty_we = 1; duty_wdata = 6'h05;
    @(negedge clk); #1; duty_we = 0;
    repeat (64) @(negedge clk); #1;
    chk(last_hi[0], 48, "R7 load-cycle write deferred");
    wait_load_cycle();
    repeat (64) @(negedge clk); #1;
    chk(last_hi[0], 5, "R7 load-cycle write applied");

    cur_tag = "R8";
    settle(8'h08, 0, 1);
    @(posedge clk); #1; rst = 1;
    @(posedge clk); #1;
    chk(int'(pwm_out), 0, "R8 mid-run reset level");
    @(posedge clk); #1; rst = 0;
    repeat (200) @(negedge clk);
    #1;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule